// File: doc/BRIEF.md
# Shared Interrupt Source Aggregator

This block folds seven peripheral interrupt events onto a single CPU interrupt request line. Each event is latched into its own sticky pending bit. Software reads the pending register to find out which source asked for service, and acknowledges an event by writing a one to that bit. A mask register enables each source on its own. The masked result then passes through a per-vector enable and a global enable before it reaches the request line.

Two of the event generators sit inside the block. The first watches the serial clock pin of the display data channel. It passes the pin through a synchronizer and a level-hold qualifier, and it raises an event only on a qualified high-to-low change. The second merges a vertical retrace pulse and a vertical frequency counter overflow into one source. It also keeps a sticky out-of-range flag that shows the overflow case apart from a normal retrace. The other five sources arrive as single-cycle pulses from their peripherals. A small synchronous register port provides write strobes and a combinational read-back.

Top module: `irq_share_top`

## Requirements
- R1: After reset, the pending register (address 0), the mask register (address 1) and the sync status register (address 2) all read 8'h00, and `irqReq` is low.
- R2: A source that is high at a rising clock edge sets its pending bit, and the bit reads back as set right after that edge. Bit positions are: 0 DSCL edge, 1 ADC done, 2 timer timeout, 3 SOA, 4 vertical event, 5 parabola tick, 6 DDC1. A pending bit sets even while its mask bit is 0, and it stays set until software clears it.
- R3: Writing to address 0 clears every pending bit whose write-data bit is 1 and leaves the other bits unchanged. If a source sets a bit in the same cycle that a write clears it, the bit stays set.
- R4: Address 1 holds the mask register in bits 6:0, and bit 7 always reads 0. Writing 8'b0000_0010 enables only the ADC source.
- R5: `irqReq` is high exactly when some pending bit has its mask bit set and `srcEnable` and `globalEnable` are both high. Pulling either enable low drops the request.
- R6: The DSCL source fires only after the pin has been sampled low on at least 12 consecutive clock edges following a qualified high level. A low pulse of 11 edges produces no event.
- R7: A qualified low-to-high change on the DSCL pin produces no event.
- R8: A pulse on `vRetrace` or on `vOverflow` sets pending bit 4. Only `vOverflow` also sets the out-of-range flag, which reads at bit 3 of address 2.
- R9: Writing 1 to bit 3 of address 2 clears the out-of-range flag. If an overflow arrives in the same cycle as that write, the flag stays set.
- R10: Address 3 always reads 8'h00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ddcClkPin | input | 1 | Raw, unsynchronized DDC serial clock pin |
| adcDone | input | 1 | A/D conversion done pulse |
| timerTick | input | 1 | Auto-reload timer timeout pulse |
| soaEvt | input | 1 | SOA condition pulse |
| vRetrace | input | 1 | Vertical retrace detected pulse |
| vOverflow | input | 1 | Vertical frequency counter overflow pulse |
| paraTick | input | 1 | Parabola generator pulse |
| ddc1Evt | input | 1 | DDC1 event pulse |
| srcEnable | input | 1 | Per-vector enable for this shared line |
| globalEnable | input | 1 | Global interrupt enable |
| regAddr | input | 2 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for the current address |
| irqReq | output | 1 | Combined interrupt request |

## Verification
A corrupted pending bit shows up on the very next read of address 0, and on `irqReq` in the same cycle whenever its mask bit is set. This makes a wrong latch or clear visible one cycle after the edge that caused it. Faults in the DSCL qualifier show up only at the edge-count boundary: the bench probes both 11 and 12 sampled low edges and waits long enough for the synchronizer and qualifier delays to pass. Same-cycle set and clear collisions on both sticky registers are driven on purpose, because a wrong priority there loses an event without any other trace.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;
  localparam int NUM_SRC = 7;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;

  // source bit positions, visible to software
  localparam int BIT_DSCL  = 0;
  localparam int BIT_ADC   = 1;
  localparam int BIT_TIMER = 2;
  localparam int BIT_SOA   = 3;
  localparam int BIT_VERT  = 4;
  localparam int BIT_PARA  = 5;
  localparam int BIT_DDC1  = 6;

  // out-of-range flag position in the sync status register
  localparam int FLAG_BIT = 3;

  localparam logic [ADDR_W-1:0] ADDR_PEND = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_SYNC = ADDR_W'(2);

  typedef struct packed {
    logic [NUM_SRC-1:0] pendClr;
    logic               maskWe;
    logic [NUM_SRC-1:0] maskData;
    logic               flagClr;
    logic [ADDR_W-1:0]  rdSel;
  } regStrobe_t;
endpackage

// File: rtl/irq_share_ctrl.sv
module irq_share_ctrl
  import irq_share_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe          = '0;
    strobe.rdSel    = regAddr;
    strobe.maskData = regWrData[NUM_SRC-1:0];
    if (regWrEn) begin
      unique case (regAddr)
        ADDR_PEND: strobe.pendClr = regWrData[NUM_SRC-1:0];
        ADDR_MASK: strobe.maskWe  = 1'b1;
        ADDR_SYNC: strobe.flagClr = regWrData[FLAG_BIT];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/irq_share_edgeq.sv
module irq_share_edgeq #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinRaw,
  output logic fallEvt
);
  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinS;
  logic                   filtQ;
  logic [CNT_W-1:0]       holdCnt;

  // synchronizer chain, idle level high
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b1;
        else       syncQ[g] <= pinRaw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b1;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  assign pinS = syncQ[SYNC_STAGES-1];

  // the level must differ from the accepted one for QUAL_CYCLES edges in a row
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtQ   <= 1'b1;
      holdCnt <= '0;
      fallEvt <= 1'b0;
    end else if (pinS == filtQ) begin
      holdCnt <= '0;
      fallEvt <= 1'b0;
    end else if (holdCnt == CNT_LAST) begin
      filtQ   <= pinS;
      holdCnt <= '0;
      fallEvt <= filtQ;
    end else begin
      holdCnt <= holdCnt + 1'b1;
      fallEvt <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_share_dpath.sv
module irq_share_dpath
  import irq_share_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcRaw,
  input  logic               vOverflow,
  input  regStrobe_t         strobe,
  input  logic               srcEnable,
  input  logic               globalEnable,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqReq
);
  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] maskQ;
  logic               flagQ;
  logic [NUM_SRC-1:0] srcSet;

  // vertical source merges retrace with overflow
  always_comb begin
    srcSet           = srcRaw;
    srcSet[BIT_VERT] = srcRaw[BIT_VERT] | vOverflow;
  end

  // sticky pending bits, a set beats a same-cycle clear
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_pend
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            pendQ[b] <= 1'b0;
      else if (srcSet[b])   pendQ[b] <= 1'b1;
      else if (strobe.pendClr[b]) pendQ[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             maskQ <= '0;
    else if (strobe.maskWe) maskQ <= strobe.maskData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               flagQ <= 1'b0;
    else if (vOverflow)      flagQ <= 1'b1;
    else if (strobe.flagClr) flagQ <= 1'b0;
  end

  assign irqReq = (|(pendQ & maskQ)) & srcEnable & globalEnable;

  always_comb begin
    regRdData = '0;
    unique case (strobe.rdSel)
      ADDR_PEND: regRdData = {{(DATA_W-NUM_SRC){1'b0}}, pendQ};
      ADDR_MASK: regRdData = {{(DATA_W-NUM_SRC){1'b0}}, maskQ};
      ADDR_SYNC: regRdData[FLAG_BIT] = flagQ;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_share_top.sv
module irq_share_top
  import irq_share_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ddcClkPin,
  input  logic              adcDone,
  input  logic              timerTick,
  input  logic              soaEvt,
  input  logic              vRetrace,
  input  logic              vOverflow,
  input  logic              paraTick,
  input  logic              ddc1Evt,
  input  logic              srcEnable,
  input  logic              globalEnable,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqReq
);
  regStrobe_t         strobe;
  logic               dsclEvt;
  logic [NUM_SRC-1:0] srcRaw;

  always_comb begin
    srcRaw            = '0;
    srcRaw[BIT_DSCL]  = dsclEvt;
    srcRaw[BIT_ADC]   = adcDone;
    srcRaw[BIT_TIMER] = timerTick;
    srcRaw[BIT_SOA]   = soaEvt;
    srcRaw[BIT_VERT]  = vRetrace;
    srcRaw[BIT_PARA]  = paraTick;
    srcRaw[BIT_DDC1]  = ddc1Evt;
  end

  irq_share_ctrl u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strobe   (strobe)
  );

  irq_share_edgeq #(
    .SYNC_STAGES(SYNC_STAGES),
    .QUAL_CYCLES(QUAL_CYCLES)
  ) u_edgeq (
    .clk    (clk),
    .rstN   (rstN),
    .pinRaw (ddcClkPin),
    .fallEvt(dsclEvt)
  );

  irq_share_dpath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .srcRaw      (srcRaw),
    .vOverflow   (vOverflow),
    .strobe      (strobe),
    .srcEnable   (srcEnable),
    .globalEnable(globalEnable),
    .regRdData   (regRdData),
    .irqReq      (irqReq)
  );
endmodule

// File: rtl/irq_share_chk.sv
module irq_share_chk
  import irq_share_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               srcEnable,
  input logic               globalEnable,
  input logic               irqReq,
  input logic               adcDone,
  input logic               vOverflow,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [NUM_SRC-1:0] pendQ,
  input logic               flagQ
);
  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (srcEnable && globalEnable));

  // R5
  irq_need_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (pendQ != '0));

  // R2
  adc_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcDone |=> pendQ[BIT_ADC]);

  // R3
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_PEND) |=> ((pendQ & $past(pendQ)) == $past(pendQ)));

  // R8
  vflag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    vOverflow |=> (flagQ && pendQ[BIT_VERT]));
endmodule

bind irq_share_top irq_share_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .srcEnable   (srcEnable),
  .globalEnable(globalEnable),
  .irqReq      (irqReq),
  .adcDone     (adcDone),
  .vOverflow   (vOverflow),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .pendQ       (u_dp.pendQ),
  .flagQ       (u_dp.flagQ)
);

// File: tb/irq_share_top_tb.sv
module irq_share_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ddcClkPin = 1'b1;
  logic       adcDone = 1'b0, timerTick = 1'b0, soaEvt = 1'b0;
  logic       vRetrace = 1'b0, vOverflow = 1'b0, paraTick = 1'b0, ddc1Evt = 1'b0;
  logic       srcEnable = 1'b1, globalEnable = 1'b1;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       irqReq;

  int nVec = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_share_top u_dut (
    .clk(clk), .rstN(rstN), .ddcClkPin(ddcClkPin),
    .adcDone(adcDone), .timerTick(timerTick), .soaEvt(soaEvt),
    .vRetrace(vRetrace), .vOverflow(vOverflow), .paraTick(paraTick),
    .ddc1Evt(ddc1Evt), .srcEnable(srcEnable), .globalEnable(globalEnable),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqReq(irqReq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = 8'h00;
  endtask

  task automatic setSrc(input int idx, input logic v);
    case (idx)
      1: adcDone = v;
      2: timerTick = v;
      3: soaEvt = v;
      5: paraTick = v;
      6: ddc1Evt = v;
      default: ;
    endcase
  endtask

  task automatic pulseSrc(input int idx);
    @(negedge clk);
    setSrc(idx, 1'b1);
    @(negedge clk);
    setSrc(idx, 1'b0);
  endtask

  task automatic clearAll();
    writeReg(2'd0, 8'h7f);
    writeReg(2'd2, 8'h08);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    readReg(2'd0, d); check("R1 pend", d, 8'h00);
    readReg(2'd1, d); check("R1 mask", d, 8'h00);
    readReg(2'd2, d); check("R1 sync", d, 8'h00);
    check("R1 irq", {7'd0, irqReq}, 8'h00);
  endtask

  task automatic t_sources();
    logic [7:0] d;
    foreach (d[i]) begin
      if (i == 1 || i == 2 || i == 3 || i == 5 || i == 6) begin
        pulseSrc(i);
        readReg(2'd0, d);
        check($sformatf("R2 src%0d", i), d, 8'(1) << i);
        check("R5 masked irq", {7'd0, irqReq}, 8'h00);
        writeReg(2'd0, 8'h7f);
        readReg(2'd0, d);
        check("R3 clear", d, 8'h00);
      end
    end
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    pulseSrc(1);
    pulseSrc(2);
    repeat (3) @(negedge clk);
    readReg(2'd0, d); check("R2 sticky", d, 8'h06);
    writeReg(2'd0, 8'h04);
    readReg(2'd0, d); check("R3 partial clear", d, 8'h02);
    writeReg(2'd0, 8'h00);
    readReg(2'd0, d); check("R3 zero write", d, 8'h02);
    // set and clear collide
    @(negedge clk);
    adcDone = 1'b1; regAddr = 2'd0; regWrData = 8'h02; regWrEn = 1'b1;
    @(negedge clk);
    adcDone = 1'b0; regWrEn = 1'b0;
    readReg(2'd0, d); check("R3 set wins", d, 8'h02);
    clearAll();
  endtask

  task automatic t_mask();
    logic [7:0] d;
    writeReg(2'd1, 8'hff);
    readReg(2'd1, d); check("R4 mask bit7", d, 8'h7f);
    writeReg(2'd1, 8'h02);
    readReg(2'd1, d); check("R4 mask rw", d, 8'h02);
    pulseSrc(2);
    check("R4 timer masked", {7'd0, irqReq}, 8'h00);
    pulseSrc(1);
    check("R5 irq on", {7'd0, irqReq}, 8'h01);
    @(negedge clk); srcEnable = 1'b0; #1;
    check("R5 vector enable", {7'd0, irqReq}, 8'h00);
    srcEnable = 1'b1; globalEnable = 1'b0; #1;
    check("R5 global enable", {7'd0, irqReq}, 8'h00);
    globalEnable = 1'b1; #1;
    check("R5 irq back", {7'd0, irqReq}, 8'h01);
    writeReg(2'd0, 8'h02);
    check("R5 irq after clear", {7'd0, irqReq}, 8'h00);
    clearAll();
    writeReg(2'd1, 8'h00);
  endtask

  task automatic t_dscl();
    logic [7:0] d;
    @(negedge clk); ddcClkPin = 1'b0;
    repeat (11) @(negedge clk);
    ddcClkPin = 1'b1;
    repeat (20) @(negedge clk);
    readReg(2'd0, d); check("R6 short pulse", d, 8'h00);
    @(negedge clk); ddcClkPin = 1'b0;
    repeat (12) @(negedge clk);
    ddcClkPin = 1'b1;
    repeat (20) @(negedge clk);
    readReg(2'd0, d); check("R6 qualified fall", d, 8'h01);
    clearAll();
    @(negedge clk); ddcClkPin = 1'b0;
    repeat (30) @(negedge clk);
    writeReg(2'd0, 8'h01);
    readReg(2'd0, d); check("R7 low held", d, 8'h00);
    @(negedge clk); ddcClkPin = 1'b1;
    repeat (30) @(negedge clk);
    readReg(2'd0, d); check("R7 rising ignored", d, 8'h00);
  endtask

  task automatic t_vert();
    logic [7:0] d;
    @(negedge clk); vRetrace = 1'b1;
    @(negedge clk); vRetrace = 1'b0;
    readReg(2'd0, d); check("R8 retrace pend", d, 8'h10);
    readReg(2'd2, d); check("R8 retrace no flag", d, 8'h00);
    clearAll();
    @(negedge clk); vOverflow = 1'b1;
    @(negedge clk); vOverflow = 1'b0;
    readReg(2'd0, d); check("R8 overflow pend", d, 8'h10);
    readReg(2'd2, d); check("R8 overflow flag", d, 8'h08);
    writeReg(2'd2, 8'h08);
    readReg(2'd2, d); check("R9 flag clear", d, 8'h00);
    @(negedge clk);
    vOverflow = 1'b1; regAddr = 2'd2; regWrData = 8'h08; regWrEn = 1'b1;
    @(negedge clk);
    vOverflow = 1'b0; regWrEn = 1'b0;
    readReg(2'd2, d); check("R9 set wins", d, 8'h08);
    clearAll();
  endtask

  task automatic t_addr3();
    logic [7:0] d;
    writeReg(2'd1, 8'h15);
    writeReg(2'd3, 8'hff);
    readReg(2'd3, d); check("R10 addr3 read", d, 8'h00);
    readReg(2'd1, d); check("R10 mask kept", d, 8'h15);
    readReg(2'd2, d); check("R10 sync kept", d, 8'h00);
    writeReg(2'd1, 8'h00);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      nVec++; nErr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_sources();
    t_w1c();
    t_mask();
    t_dscl();
    t_vert();
    t_addr3();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end
endmodule